// File: doc/BRIEF.md
# Bus Mastership Release Controller

This block lets a processor that normally owns the external bus hand it over to another master on request, and take it back afterwards. A second master pulls an active-low request line. The controller waits until the bus cycle in progress has ended and no indivisible transaction is running. If an SDRAM bank is open, it first has a precharge-all command issued. It then floats the address and data buses. Half a bus cycle later it grants the bus through an active-low acknowledge. It drives the control strobes to their inactive high level for one bus cycle and then floats them. When the request goes away, it drops the acknowledge and drives the buses again.

The block has one clock, `clk`, which ticks twice per bus-clock period. `phase_i` says which bus-clock edge the coming `clk` edge stands for: 1 for a falling edge, 0 for a rising edge. Each pad group (address, data, control) has an active-high output-enable, so the float timing of every group can be seen directly. A stall output stops the internal bus state machine from starting new cycles while the handover is under way.

Top module: `bus_release_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), all three output enables are 1, `bus_ack_n_o` is 1, and `strb_hi_o`, `pall_req_o` and `stall_o` are 0.
- R2: `bus_req_n_i` is sampled only at edges where `phase_i` is 1 (falling edges). A low level present only at edges where `phase_i` is 0 starts no release.
- R3: While `cyc_busy_i` is 1 (a cycle in progress, including one stretched by wait states), the buses are not floated and no acknowledge is given.
- R4: While any bit of `lock_i` is 1, the buses are not floated. The bits mean: bit 0 a 16-byte cache line fill, bit 1 a cache copy-back, bit 2 the gap between the read and the write of an atomic test-and-set, bit 3 a run of narrow-bus sub-cycles that make up one wide access, bit 4 a 16-byte DMA burst.
- R5: If `sdram_open_i` is 1 when the hold clears, `pall_req_o` goes to 1 and stays there, with all buses still driven, until `pall_done_i` is seen. `pall_req_o` is 0 on the edge after that. With no bank open, `pall_req_o` stays 0.
- R6: `addr_oe_o` and `data_oe_o` always have equal values, and they fall together at an edge where `phase_i` is 0.
- R7: `bus_ack_n_o` goes low exactly one tick after the buses float, at an edge where `phase_i` is 1.
- R8: One tick after the acknowledge, `strb_hi_o` rises (all strobes held inactive high). Two ticks later, at the next rising edge, `ctrl_oe_o` falls and `strb_hi_o` returns to 0 at the same edge.
- R9: Once the bus is released and the request is seen high, `bus_ack_n_o` rises at an edge where `phase_i` is 1. All three output enables return to 1 exactly one tick later.
- R10: `stall_o` is 0 while the hold is still active and becomes 1 in the same cycle the hold clears, with no clock edge in between. It stays 1 until the enables are restored, and it is 1 whenever the acknowledge is low.
- R11: If the request is withdrawn while the controller is still waiting for the hold to clear, it goes back to owning the bus without floating anything or acknowledging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock (two ticks per bus clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | 1 | 1: this edge is a bus-clock falling edge; 0: rising edge |
| bus_req_n_i | input | 1 | Active-low bus request from the other master |
| cyc_busy_i | input | 1 | Bus cycle in progress (including wait-stretched cycles) |
| lock_i | input | NUM_LOCK | Indivisible-sequence flags, see R4 |
| sdram_open_i | input | 1 | At least one SDRAM bank is open |
| pall_done_i | input | 1 | Precharge-all command has completed |
| addr_oe_o | output | 1 | Address bus output enable |
| data_oe_o | output | 1 | Data bus output enable |
| ctrl_oe_o | output | 1 | Control strobe output enable |
| strb_hi_o | output | 1 | Force all control strobes to inactive high |
| bus_ack_n_o | output | 1 | Active-low bus grant |
| pall_req_o | output | 1 | Request a precharge-all command |
| stall_o | output | 1 | Block new internal bus cycles |

## Verification
Two things can happen in the same cycle: the hold clears, and the internal bus state machine starts a new cycle. That is why `stall_o` must rise in the very cycle `cyc_busy_i` falls, not one edge later. The bench holds the controller in its waiting state with `cyc_busy_i` high and checks that `stall_o` is low. It then drops `cyc_busy_i` between edges and samples `stall_o` before the next edge, expecting 1. The release that follows must keep the normal edge-by-edge spacing.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus release controller.
// Assumes: one controller state machine per bus port.
package brc_pkg;
    typedef enum logic [3:0] {
        ST_OWNED, ST_WAIT_UNLOCK, ST_PRECHARGE, ST_FLOAT_BUS, ST_ACK,
        ST_STROBE_HIGH, ST_FLOAT_CTRL, ST_RELEASED, ST_RECLAIM
    } brc_state_e;

    // Positions of the indivisible-sequence flags in the lock vector.
    localparam int LK_LINE_FILL  = 0;
    localparam int LK_COPYBACK   = 1;
    localparam int LK_ATOMIC_GAP = 2;
    localparam int LK_NARROW_SEQ = 3;
    localparam int LK_DMA_BURST  = 4;
    localparam int LK_COUNT      = 5;
endpackage

// File: rtl/brc_req_sample.sv
`timescale 1ns/1ps
// Samples the active-low external bus request at bus-clock falling edges
// only, and presents it as an active-high "request asserted" flag.
// Assumes: phase_i is 1 for clk edges that stand for falling bus-clock edges.
module brc_req_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic req_n_i,
    output logic req_act_o
);
    logic req_n_q;

    // Capture the request pin on falling-phase edges only.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_n_q <= 1'b1;
        else if (phase_i) req_n_q <= req_n_i;
    end

    assign req_act_o = !req_n_q;

    AST_REQ_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_n_q) |-> $past(phase_i)); // R2
endmodule

// File: rtl/brc_hold_gate.sv
`timescale 1ns/1ps
// Combines the cycle-in-progress flag and the indivisible-sequence flags
// into one "safe to release" indication.
// Assumes: every flag is active high and already synchronous to clk.
module brc_hold_gate #(
    parameter int NUM_LOCK = 5
) (
    input  logic                cyc_busy_i,
    input  logic [NUM_LOCK-1:0] lock_i,
    output logic                clear_o
);
    logic [NUM_LOCK:0] any_hold;

    // Ripple OR over the lock flags, seeded with the busy flag.
    assign any_hold[0] = cyc_busy_i;
    for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock
        assign any_hold[g+1] = any_hold[g] | lock_i[g];
    end

    assign clear_o = !any_hold[NUM_LOCK];
endmodule

// File: rtl/brc_seq_fsm.sv
`timescale 1ns/1ps
// Release/reclaim sequencer. It walks the hold wait, the optional SDRAM
// precharge-all, the staggered float of buses, acknowledge and strobes,
// and the reclaim. All pad controls are registered.
// Assumes: phase_i alternates every clk; req_act_i is already phase sampled.
module brc_seq_fsm
    import brc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic req_act_i,
    input  logic clear_i,
    input  logic sdram_open_i,
    input  logic pall_done_i,
    output logic addr_oe_o,
    output logic data_oe_o,
    output logic ctrl_oe_o,
    output logic strb_hi_o,
    output logic ack_n_o,
    output logic pall_req_o,
    output logic stall_o
);
    brc_state_e state;
    logic addr_oe_q, data_oe_q, ctrl_oe_q, strb_hi_q, ack_n_q, pall_req_q;
    logic fall_tick, rise_tick;

    assign fall_tick = phase_i;
    assign rise_tick = !phase_i;

    // Sequence state and registered pad controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OWNED;
            addr_oe_q  <= 1'b1;
            data_oe_q  <= 1'b1;
            ctrl_oe_q  <= 1'b1;
            strb_hi_q  <= 1'b0;
            ack_n_q    <= 1'b1;
            pall_req_q <= 1'b0;
        end else begin
            case (state)
                ST_OWNED: if (req_act_i) state <= ST_WAIT_UNLOCK;
                ST_WAIT_UNLOCK: begin
                    if (!req_act_i) begin
                        state <= ST_OWNED;
                    end else if (clear_i) begin
                        if (sdram_open_i) begin
                            state      <= ST_PRECHARGE;
                            pall_req_q <= 1'b1;
                        end else begin
                            state <= ST_FLOAT_BUS;
                        end
                    end
                end
                ST_PRECHARGE: if (pall_done_i) begin
                    pall_req_q <= 1'b0;
                    state      <= ST_FLOAT_BUS;
                end
                ST_FLOAT_BUS: if (rise_tick) begin
                    addr_oe_q <= 1'b0;
                    data_oe_q <= 1'b0;
                    state     <= ST_ACK;
                end
                ST_ACK: if (fall_tick) begin
                    ack_n_q <= 1'b0;
                    state   <= ST_STROBE_HIGH;
                end
                ST_STROBE_HIGH: if (rise_tick) begin
                    strb_hi_q <= 1'b1;
                    state     <= ST_FLOAT_CTRL;
                end
                ST_FLOAT_CTRL: if (rise_tick) begin
                    ctrl_oe_q <= 1'b0;
                    strb_hi_q <= 1'b0;
                    state     <= ST_RELEASED;
                end
                ST_RELEASED: if (fall_tick && !req_act_i) begin
                    ack_n_q <= 1'b1;
                    state   <= ST_RECLAIM;
                end
                ST_RECLAIM: if (rise_tick) begin
                    addr_oe_q <= 1'b1;
                    data_oe_q <= 1'b1;
                    ctrl_oe_q <= 1'b1;
                    state     <= ST_OWNED;
                end
                default: state <= ST_OWNED;
            endcase
        end
    end

    // Stall: committed handover, or the very cycle the hold clears.
    always_comb begin
        if (state == ST_OWNED)            stall_o = 1'b0;
        else if (state == ST_WAIT_UNLOCK) stall_o = req_act_i && clear_i;
        else                              stall_o = 1'b1;
    end

    assign addr_oe_o  = addr_oe_q;
    assign data_oe_o  = data_oe_q;
    assign ctrl_oe_o  = ctrl_oe_q;
    assign strb_hi_o  = strb_hi_q;
    assign ack_n_o    = ack_n_q;
    assign pall_req_o = pall_req_q;

    AST_PALL_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        pall_req_q |-> (addr_oe_q && ctrl_oe_q)); // R5
    AST_BUS_FLOAT_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe_q) |-> !$past(phase_i)); // R6
    AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_q |-> (!addr_oe_q && !data_oe_q)); // R7
    AST_ACK_ON_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_q) |-> $past(phase_i)); // R7
    AST_STROBES_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_oe_q) |-> $past(strb_hi_q)); // R8
    AST_UNGRANT_ON_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n_q) |-> $past(phase_i)); // R9
    AST_STALL_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_q |-> stall_o); // R10
endmodule

// File: rtl/bus_release_ctrl.sv
`timescale 1ns/1ps
// Top of the bus mastership release controller. It ties together request
// sampling, the hold gate and the release sequencer.
// Assumes: clk runs at twice the bus clock, and phase_i marks falling edges.
module bus_release_ctrl #(
    parameter int NUM_LOCK = brc_pkg::LK_COUNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phase_i,
    input  logic                bus_req_n_i,
    input  logic                cyc_busy_i,
    input  logic [NUM_LOCK-1:0] lock_i,
    input  logic                sdram_open_i,
    input  logic                pall_done_i,
    output logic                addr_oe_o,
    output logic                data_oe_o,
    output logic                ctrl_oe_o,
    output logic                strb_hi_o,
    output logic                bus_ack_n_o,
    output logic                pall_req_o,
    output logic                stall_o
);
    logic req_act, hold_clear;

    brc_req_sample u_req (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
        .req_n_i(bus_req_n_i), .req_act_o(req_act)
    );

    brc_hold_gate #(.NUM_LOCK(NUM_LOCK)) u_hold (
        .cyc_busy_i(cyc_busy_i), .lock_i(lock_i), .clear_o(hold_clear)
    );

    brc_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
        .req_act_i(req_act), .clear_i(hold_clear),
        .sdram_open_i(sdram_open_i), .pall_done_i(pall_done_i),
        .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o), .ctrl_oe_o(ctrl_oe_o),
        .strb_hi_o(strb_hi_o), .ack_n_o(bus_ack_n_o),
        .pall_req_o(pall_req_o), .stall_o(stall_o)
    );

    AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_busy_i || (|lock_i)) && addr_oe_o && !pall_req_o) |=> addr_oe_o); // R3 R4
    AST_OE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe_o == data_oe_o); // R6
endmodule

// File: tb/bus_release_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for the bus release controller.
module bus_release_ctrl_tb_top;
    localparam int NL = 5;

    logic clk = 1'b0, rst_n = 1'b0, ph = 1'b0;
    logic req_n = 1'b1, busy = 1'b0, sdo = 1'b0, pdone = 1'b0;
    logic [NL-1:0] lock = '0;
    logic addr_oe, data_oe, ctrl_oe, strb_hi, ack_n, pall_req, stall;

    int n_chk = 0, n_bad = 0, tcount = 0, wd = 0;
    logic lph = 1'b0;

    always #2 clk = ~clk;           // 250 MHz
    always @(negedge clk) ph <= ~ph;

    bus_release_ctrl #(.NUM_LOCK(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_i(ph), .bus_req_n_i(req_n),
        .cyc_busy_i(busy), .lock_i(lock), .sdram_open_i(sdo),
        .pall_done_i(pdone), .addr_oe_o(addr_oe), .data_oe_o(data_oe),
        .ctrl_oe_o(ctrl_oe), .strb_hi_o(strb_hi), .bus_ack_n_o(ack_n),
        .pall_req_o(pall_req), .stall_o(stall)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<=20000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        tcount++;
        lph = ph;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Watch a release unfold and check edge placement and spacing.
    task automatic watch_release(input string tag);
        int ta = -1, tk = -1, ts = -1, tc = -1, mism = 0;
        logic pa = 1'b1, pk = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (addr_oe != data_oe) mism++;
            if (ta < 0 && !addr_oe) begin ta = i; pa = lph; end
            if (tk < 0 && !ack_n)   begin tk = i; pk = lph; end
            if (ts < 0 && strb_hi)  ts = i;
            if (tc < 0 && !ctrl_oe) tc = i;
        end
        chk(ta >= 0 && pa == 1'b0, {tag, " R6 buses float on rising"}, int'(pa), 0);
        chk(mism == 0, {tag, " R6 addr/data enables paired"}, mism, 0);
        chk(tk == ta + 1 && pk == 1'b1, {tag, " R7 ack one tick later on falling"}, tk - ta, 1);
        chk(ts == tk + 1, {tag, " R8 strobes high next tick"}, ts - tk, 1);
        chk(tc == ts + 2, {tag, " R8 strobes float one cycle later"}, tc - ts, 2);
        chk(strb_hi == 1'b0, {tag, " R8 strobe force dropped"}, int'(strb_hi), 0);
        chk(stall == 1'b1, {tag, " R10 stall while released"}, int'(stall), 1);
    endtask

    // Withdraw the request and check the reclaim.
    task automatic watch_reclaim(input string tag);
        int ta = -1, to = -1;
        logic pa = 1'b0;
        req_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (ta < 0 && ack_n) begin ta = i; pa = lph; end
            if (to < 0 && addr_oe && data_oe && ctrl_oe) to = i;
        end
        chk(ta >= 0 && pa == 1'b1, {tag, " R9 ack negated on falling"}, int'(pa), 1);
        chk(to == ta + 1, {tag, " R9 enables back one tick later"}, to - ta, 1);
        chk(stall == 1'b0, {tag, " R10 stall cleared after reclaim"}, int'(stall), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ticks(4);
        rst_n = 1'b1;
        chk(addr_oe && data_oe && ctrl_oe, "R1 enables after reset", int'({addr_oe, data_oe, ctrl_oe}), 7);
        chk(ack_n == 1'b1, "R1 ack after reset", int'(ack_n), 1);
        chk(!strb_hi && !pall_req && !stall, "R1 idle outputs after reset",
            int'({strb_hi, pall_req, stall}), 0);
    endtask

    task automatic t_plain();
        req_n = 1'b0;
        watch_release("plain");
        chk(pall_req == 1'b0, "R5 no precharge when no bank open", int'(pall_req), 0);
        watch_reclaim("plain");
    endtask

    task automatic t_busy_same_cycle();
        busy = 1'b1;
        req_n = 1'b0;
        ticks(10);
        chk(addr_oe == 1'b1 && ack_n == 1'b1, "R3 busy holds bus", int'(addr_oe), 1);
        chk(stall == 1'b0, "R10 no stall while hold active", int'(stall), 0);
        busy = 1'b0;
        #1;
        chk(stall == 1'b1, "R10 stall rises in the clearing cycle", int'(stall), 1);
        watch_release("busy");
        watch_reclaim("busy");
    endtask

    task automatic t_locks();
        for (int b = 0; b < NL; b++) begin
            lock = '0;
            lock[b] = 1'b1;
            req_n = 1'b0;
            ticks(8);
            chk(addr_oe == 1'b1 && ack_n == 1'b1, $sformatf("R4 lock bit %0d holds bus", b), int'(addr_oe), 1);
            lock = '0;
            watch_release($sformatf("lock%0d", b));
            watch_reclaim($sformatf("lock%0d", b));
        end
    endtask

    task automatic t_precharge();
        sdo = 1'b1;
        req_n = 1'b0;
        ticks(6);
        chk(pall_req == 1'b1, "R5 precharge requested", int'(pall_req), 1);
        chk(addr_oe && ctrl_oe && ack_n, "R5 bus driven during precharge",
            int'({addr_oe, ctrl_oe, ack_n}), 7);
        pdone = 1'b1;
        tick();
        pdone = 1'b0;
        sdo = 1'b0;
        chk(pall_req == 1'b0, "R5 precharge request drops after done", int'(pall_req), 0);
        watch_release("pall");
        watch_reclaim("pall");
    endtask

    task automatic t_abort();
        busy = 1'b1;
        req_n = 1'b0;
        ticks(6);
        req_n = 1'b1;
        ticks(6);
        busy = 1'b0;
        ticks(6);
        chk(addr_oe && ctrl_oe && ack_n, "R11 withdrawn request leaves bus owned",
            int'({addr_oe, ctrl_oe, ack_n}), 7);
        chk(stall == 1'b0, "R11 no stall after withdrawal", int'(stall), 0);
    endtask

    task automatic t_phase_reject();
        tick();
        while (lph != 1'b1) tick();
        req_n = 1'b0;   // seen only at the coming rising-phase edge
        tick();
        req_n = 1'b1;
        ticks(8);
        chk(addr_oe == 1'b1 && ack_n == 1'b1, "R2 rising-phase request ignored", int'(addr_oe), 1);
        chk(stall == 1'b0, "R2 no stall from ignored request", int'(stall), 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_busy_same_cycle();
        t_locks();
        t_precharge();
        t_abort();
        t_phase_reject();
        t_plain();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule